// File: doc/BRIEF.md
# Accumulator Execute Stage with Status Flags

This block is the execute stage of a small accumulator machine with 12-bit instruction words and an 8-bit datapath. It holds the working register W and three status flags: carry, digit carry (the carry out of the low nibble) and zero. In each cycle the surrounding pipeline presents a decoded instruction word, the 8-bit value read from the addressed file register and a valid strobe. The block then works out the result and reports whether it is bound for W or for the file register.

A result bound for W, and any flag change, takes effect on the next rising clock edge. A result bound for the file register leaves the block in the same cycle as a write-enable/write-data pair, so the register file can capture it on that same edge. Three groups of operations are in scope: byte-wide operations on a file operand and W, single-bit clear and set on a file operand, and operations with an 8-bit literal. Instruction fetch, branching, skips and the register file itself sit outside the block.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, W reads 0x00 and the carry, digit-carry and zero flags all read 0.
- R2: For byte-wide operations, which have a 6-bit opcode in bits [11:6], bit [5] selects the destination. 0 writes the result to W and asserts no file write. 1 asserts `file_wr_en` with the result on `file_wr_data` and leaves W unchanged. `dest_file` mirrors the chosen destination.
- R3: Opcode 000111 adds the file operand and W. Carry is the carry out of bit 7, digit carry is the carry out of bit 3, and zero marks an 8-bit result of 0.
- R4: Opcode 000010 computes the file operand minus W, modulo 256. Carry is 1 when the operand is at least W (no borrow). Digit carry is 1 when the operand's low nibble is at least W's low nibble. Zero is updated as for add.
- R5: Opcode 001101 rotates the operand left through carry and opcode 001100 rotates it right through carry. The bit shifted out becomes the new carry and the old carry enters the vacated end. Digit carry and zero do not change.
- R6: The following operations update only the zero flag: AND with W (000101), OR with W (000100), XOR with W (000110), complement (001001), move operand (001000), decrement (000011) and increment (001010). Decrement and increment wrap modulo 256.
- R7: Opcode 001110 exchanges bits [7:4] and [3:0] of the operand and leaves all three flags unchanged.
- R8: Word pattern 0000011fffff writes 0x00 to the file and sets zero. The fixed word 0x040 clears W and sets zero. Pattern 0000001fffff writes W to the file and changes no flag.
- R9: Top nibbles 0100 (clear) and 0101 (set) force bit `instr[7:5]` of the operand to 0 or 1. The result is written to the file and no flag changes.
- R10: Top nibbles 1100 (load), 1101 (OR), 1110 (AND) and 1111 (XOR) combine W with the literal `instr[7:0]` and write the result to W. The last three update zero; load changes no flag.
- R11: Any word not covered by R2 to R10 changes neither W nor any flag and asserts no file write.
- R12: With `instr_valid` low, nothing changes and `file_wr_en` stays low, whatever the instruction word.
- R13: `file_wr_en`, `file_wr_data` and `dest_file` follow the inputs within the same cycle. W and the flags change only on the rising edge that ends the accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word in this cycle is to be executed |
| instr | input | 12 | Instruction word |
| file_rd_data | input | 8 | Value of the addressed file register |
| w_out | output | 8 | Working register W |
| c_flag | output | 1 | Carry flag |
| dc_flag | output | 1 | Digit-carry flag |
| z_flag | output | 1 | Zero flag |
| dest_file | output | 1 | Decoded destination, 1 = file register, 0 = W |
| file_wr_en | output | 1 | File register write strobe for this cycle |
| file_wr_data | output | 8 | Data for the file register write |

## Verification
The file write pair is combinational, so the bench samples it 1 ns after it drives the falling edge, in the same cycle as the stimulus. W and the three flags have a latency of exactly one register. The bench reads them 1 ns after the following rising edge. At that first sample it also confirms that they still held their old values before the edge. Every instruction goes through this two-sample pattern against a running model of W and the flags. That model is advanced only when the bench's own decoding says the word is accepted. An off-by-one-cycle update, or a flag written by the wrong operation, therefore shows up at the first sample that follows it.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  localparam int DW  = 8;
  localparam int IW  = 12;
  localparam int NIB = DW / 2;
  localparam int BW  = $clog2(DW);

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV,
    OP_DEC, OP_INC, OP_RL, OP_RR, OP_SWAP, OP_CLR, OP_MOVW,
    OP_BCLR, OP_BSET, OP_LMOV, OP_LIOR, OP_LAND, OP_LXOR
  } op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flag_t;

  typedef struct packed {
    op_e           op;
    logic          legal;
    logic          to_file;
    flag_t         upd;
    logic [BW-1:0] bitsel;
  } dec_t;

  // {carry out, nibble carry out, sum}
  function automatic logic [DW+1:0] add_nib(input logic [DW-1:0] a,
                                            input logic [DW-1:0] b,
                                            input logic cin);
    logic [NIB:0] lo;
    logic [DW:0]  full;
    lo   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    return {full[DW], lo[NIB], full[DW-1:0]};
  endfunction

  // Subtract as a + ~b + 1: carries equal "no borrow"
  function automatic logic [DW+1:0] sub_nib(input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    return add_nib(a, ~b, 1'b1);
  endfunction

  function automatic flag_t flags_for(input op_e op);
    flag_t f;
    f = '0;
    case (op)
      OP_ADD, OP_SUB:       f = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      OP_RL, OP_RR:         f = '{c: 1'b1, dc: 1'b0, z: 1'b0};
      OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV, OP_DEC, OP_INC, OP_CLR,
      OP_LIOR, OP_LAND, OP_LXOR:
                            f = '{c: 1'b0, dc: 1'b0, z: 1'b1};
      default:              f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/acc_decoder.sv
module acc_decoder
  import acc_exec_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          dec
);

  op_e  op;
  logic to_file;

  always_comb begin
    op      = OP_NONE;
    to_file = instr[5];
    case (instr[11:8])
      4'b0100: begin op = OP_BCLR; to_file = 1'b1; end
      4'b0101: begin op = OP_BSET; to_file = 1'b1; end
      4'b1100: begin op = OP_LMOV; to_file = 1'b0; end
      4'b1101: begin op = OP_LIOR; to_file = 1'b0; end
      4'b1110: begin op = OP_LAND; to_file = 1'b0; end
      4'b1111: begin op = OP_LXOR; to_file = 1'b0; end
      default: begin
        case (instr[11:6])
          6'b000111: op = OP_ADD;
          6'b000010: op = OP_SUB;
          6'b000101: op = OP_AND;
          6'b000100: op = OP_IOR;
          6'b000110: op = OP_XOR;
          6'b001001: op = OP_COM;
          6'b001000: op = OP_MOV;
          6'b000011: op = OP_DEC;
          6'b001010: op = OP_INC;
          6'b001101: op = OP_RL;
          6'b001100: op = OP_RR;
          6'b001110: op = OP_SWAP;
          6'b000001: begin
            if (instr[5])                  op = OP_CLR;
            else if (instr[4:0] == 5'd0)   op = OP_CLR;
            else                           op = OP_NONE;
          end
          6'b000000: begin
            if (instr[5]) op = OP_MOVW;
            else          op = OP_NONE;
          end
          default:   op = OP_NONE;
        endcase
      end
    endcase
  end

  assign dec.op      = op;
  assign dec.legal   = (op != OP_NONE);
  assign dec.to_file = to_file;
  assign dec.upd     = flags_for(op);
  assign dec.bitsel  = instr[7:5];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] lit,
  input  logic [BW-1:0] bitsel,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          c_new,
  output logic          dc_new
);

  logic [DW+1:0] sum_w;
  logic [DW+1:0] dif_w;
  logic [DW-1:0] bmask;

  assign sum_w = add_nib(opnd, w, 1'b0);
  assign dif_w = sub_nib(opnd, w);
  assign bmask = {{(DW-1){1'b0}}, 1'b1} << bitsel;

  always_comb begin
    res    = '0;
    c_new  = cin;
    dc_new = 1'b0;
    case (op)
      OP_ADD:  begin res = sum_w[DW-1:0]; c_new = sum_w[DW+1]; dc_new = sum_w[DW]; end
      OP_SUB:  begin res = dif_w[DW-1:0]; c_new = dif_w[DW+1]; dc_new = dif_w[DW]; end
      OP_AND:  res = opnd & w;
      OP_IOR:  res = opnd | w;
      OP_XOR:  res = opnd ^ w;
      OP_COM:  res = ~opnd;
      OP_MOV:  res = opnd;
      OP_DEC:  res = opnd - 1'b1;
      OP_INC:  res = opnd + 1'b1;
      OP_RL:   begin res = {opnd[DW-2:0], cin}; c_new = opnd[DW-1]; end
      OP_RR:   begin res = {cin, opnd[DW-1:1]}; c_new = opnd[0]; end
      OP_SWAP: res = {opnd[NIB-1:0], opnd[DW-1:NIB]};
      OP_CLR:  res = '0;
      OP_MOVW: res = w;
      OP_BCLR: res = opnd & ~bmask;
      OP_BSET: res = opnd | bmask;
      OP_LMOV: res = lit;
      OP_LIOR: res = w | lit;
      OP_LAND: res = w & lit;
      OP_LXOR: res = w ^ lit;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] file_rd_data,
  output logic [DW-1:0] w_out,
  output logic          c_flag,
  output logic          dc_flag,
  output logic          z_flag,
  output logic          dest_file,
  output logic          file_wr_en,
  output logic [DW-1:0] file_wr_data
);

  dec_t          dec;
  logic [DW-1:0] w_q;
  flag_t         st_q;
  logic [DW-1:0] alu_res;
  logic          alu_c;
  logic          alu_dc;

  // Named internal events
  logic op_legal;
  logic op_accept;
  logic w_we;
  logic c_we;
  logic dc_we;
  logic z_we;
  logic res_zero;

  acc_decoder u_dec (
    .instr (instr),
    .dec   (dec)
  );

  acc_alu u_alu (
    .op     (dec.op),
    .opnd   (file_rd_data),
    .w      (w_q),
    .lit    (instr[DW-1:0]),
    .bitsel (dec.bitsel),
    .cin    (st_q.c),
    .res    (alu_res),
    .c_new  (alu_c),
    .dc_new (alu_dc)
  );

  assign op_legal  = dec.legal;
  assign op_accept = instr_valid & op_legal;
  assign w_we      = op_accept & ~dec.to_file;
  assign c_we      = op_accept & dec.upd.c;
  assign dc_we     = op_accept & dec.upd.dc;
  assign z_we      = op_accept & dec.upd.z;
  assign res_zero  = (alu_res == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q  <= '0;
      st_q <= '0;
    end else begin
      if (w_we)  w_q     <= alu_res;
      if (c_we)  st_q.c  <= alu_c;
      if (dc_we) st_q.dc <= alu_dc;
      if (z_we)  st_q.z  <= res_zero;
    end
  end

  assign w_out        = w_q;
  assign c_flag       = st_q.c;
  assign dc_flag      = st_q.dc;
  assign z_flag       = st_q.z;
  assign dest_file    = dec.to_file;
  assign file_wr_en   = op_accept & dec.to_file;
  assign file_wr_data = alu_res;

endmodule

// File: rtl/acc_exec_checker.sv
module acc_exec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [11:0] instr,
  input logic        op_legal,
  input logic        w_we,
  input logic        c_we,
  input logic        dc_we,
  input logic        z_we,
  input logic [7:0]  w_out,
  input logic        c_flag,
  input logic        dc_flag,
  input logic        z_flag,
  input logic        file_wr_en
);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable(w_out) && $stable(c_flag) && $stable(dc_flag) && $stable(z_flag)));

  assert_idle_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !file_wr_en);

  assert_illegal_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !op_legal) |=> ($stable(w_out) && $stable(c_flag) && $stable(dc_flag) && $stable(z_flag)));

  assert_illegal_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !op_legal) |-> !file_wr_en);

  assert_file_dest_keeps_w_R2: assert property (@(posedge clk) disable iff (!rst_n)
    file_wr_en |=> $stable(w_out));

  assert_single_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({file_wr_en, w_we}));

  assert_carry_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !c_we |=> $stable(c_flag));

  assert_digit_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dc_we |=> $stable(dc_flag));

  assert_zero_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !z_we |=> $stable(z_flag));

  assert_clear_w_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr == 12'h040) |=> (w_out == 8'h00 && z_flag));

  assert_literal_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[11:8] == 4'b1100) |=> (w_out == $past(instr[7:0])));

endmodule

bind acc_exec_unit acc_exec_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .op_legal    (op_legal),
  .w_we        (w_we),
  .c_we        (c_we),
  .dc_we       (dc_we),
  .z_we        (z_we),
  .w_out       (w_out),
  .c_flag      (c_flag),
  .dc_flag     (dc_flag),
  .z_flag      (z_flag),
  .file_wr_en  (file_wr_en)
);

// File: tb/acc_exec_unit_test.sv
module acc_exec_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [11:0] instr;
  logic [7:0]  file_rd_data;
  logic [7:0]  w_out;
  logic        c_flag, dc_flag, z_flag;
  logic        dest_file, file_wr_en;
  logic [7:0]  file_wr_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_w;
  logic       m_c, m_dc, m_z;

  always #5 clk = ~clk;

  acc_exec_unit uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr        (instr),
    .file_rd_data (file_rd_data),
    .w_out        (w_out),
    .c_flag       (c_flag),
    .dc_flag      (dc_flag),
    .z_flag       (z_flag),
    .dest_file    (dest_file),
    .file_wr_en   (file_wr_en),
    .file_wr_data (file_wr_data)
  );

  // Independent model of the instruction set, written with integer arithmetic
  function automatic void predict(input logic [11:0] i, input logic [7:0] f,
                                  input logic [7:0] w, input logic cin,
                                  output bit legal, output bit to_file, output int res,
                                  output bit uc, output bit udc, output bit uz,
                                  output bit nc, output bit ndc, output string tag);
    int fi, wi, k, b;
    fi = f; wi = w; k = i[7:0]; b = i[7:5];
    legal = 1; to_file = i[5]; res = 0;
    uc = 0; udc = 0; uz = 0; nc = 0; ndc = 0; tag = "R11";
    casez (i)
      12'b0100_????????: begin to_file = 1; res = fi & (255 - (1 << b)); tag = "R9"; end
      12'b0101_????????: begin to_file = 1; res = fi | (1 << b); tag = "R9"; end
      12'b1100_????????: begin to_file = 0; res = k; tag = "R10"; end
      12'b1101_????????: begin to_file = 0; res = wi | k; uz = 1; tag = "R10"; end
      12'b1110_????????: begin to_file = 0; res = wi & k; uz = 1; tag = "R10"; end
      12'b1111_????????: begin to_file = 0; res = wi ^ k; uz = 1; tag = "R10"; end
      12'b000111_??????: begin
        res = fi + wi; uc = 1; udc = 1; uz = 1;
        nc = (res > 255); ndc = ((fi % 16) + (wi % 16)) > 15; tag = "R3";
      end
      12'b000010_??????: begin
        res = (fi - wi + 256) % 256; uc = 1; udc = 1; uz = 1;
        nc = (fi >= wi); ndc = (fi % 16) >= (wi % 16); tag = "R4";
      end
      12'b000101_??????: begin res = fi & wi; uz = 1; tag = "R6"; end
      12'b000100_??????: begin res = fi | wi; uz = 1; tag = "R6"; end
      12'b000110_??????: begin res = fi ^ wi; uz = 1; tag = "R6"; end
      12'b001001_??????: begin res = 255 - fi; uz = 1; tag = "R6"; end
      12'b001000_??????: begin res = fi; uz = 1; tag = "R6"; end
      12'b000011_??????: begin res = (fi + 255) % 256; uz = 1; tag = "R6"; end
      12'b001010_??????: begin res = (fi + 1) % 256; uz = 1; tag = "R6"; end
      12'b001101_??????: begin res = fi * 2 + int'(cin); uc = 1; nc = (fi >= 128); tag = "R5"; end
      12'b001100_??????: begin res = fi / 2 + int'(cin) * 128; uc = 1; nc = (fi % 2) == 1; tag = "R5"; end
      12'b001110_??????: begin res = (fi % 16) * 16 + fi / 16; tag = "R7"; end
      12'b0000011_?????: begin to_file = 1; res = 0; uz = 1; tag = "R8"; end
      12'b000001000000:  begin to_file = 0; res = 0; uz = 1; tag = "R8"; end
      12'b0000001_?????: begin to_file = 1; res = wi; tag = "R8"; end
      default:           legal = 0;
    endcase
    res = res % 256;
  endfunction

  task automatic apply(input logic [11:0] i, input logic [7:0] f, input logic v);
    bit legal, tf, uc, udc, uz, nc, ndc, act;
    int res;
    string tag;
    logic [7:0] r8;
    predict(i, f, m_w, m_c, legal, tf, res, uc, udc, uz, nc, ndc, tag);
    if (!v) tag = "R12";
    act = v && legal;
    r8  = res[7:0];
    @(negedge clk);
    instr_valid  = v;
    instr        = i;
    file_rd_data = f;
    #1;
    // Same-cycle file write; W and flags must still hold old values (R2, R13)
    checks++;
    if (file_wr_en !== (act && tf) || (act && tf && file_wr_data !== r8) ||
        (act && dest_file !== tf) ||
        w_out !== m_w || c_flag !== m_c || dc_flag !== m_dc || z_flag !== m_z) begin
      errors++;
      $display("FAIL %s R2 R13 instr=%h f=%h: wr_en=%b data=%h dest=%b w=%h cdz=%b%b%b expected wr_en=%b data=%h dest=%b w=%h cdz=%b%b%b",
               tag, i, f, file_wr_en, file_wr_data, dest_file, w_out, c_flag, dc_flag, z_flag,
               act && tf, r8, tf, m_w, m_c, m_dc, m_z);
    end
    if (act) begin
      if (!tf) m_w = r8;
      if (uc)  m_c = nc;
      if (udc) m_dc = ndc;
      if (uz)  m_z = (r8 == 8'h00);
    end
    @(posedge clk);
    #1;
    checks++;
    if (w_out !== m_w || c_flag !== m_c || dc_flag !== m_dc || z_flag !== m_z) begin
      errors++;
      $display("FAIL %s state instr=%h f=%h v=%b: w=%h cdz=%b%b%b expected w=%h cdz=%b%b%b",
               tag, i, f, v, w_out, c_flag, dc_flag, z_flag, m_w, m_c, m_dc, m_z);
    end
  endtask

  task automatic load_w(input logic [7:0] k);
    apply({4'b1100, k}, 8'h00, 1'b1);
  endtask

  task automatic set_carry(input logic cin);
    apply(12'b001100_1_00000, {7'd0, cin}, 1'b1);
  endtask

  localparam logic [5:0] ZOPS [8] = '{6'b000101, 6'b000100, 6'b000110, 6'b001001,
                                     6'b001000, 6'b000011, 6'b001010, 6'b001110};
  localparam logic [7:0] WSET [3] = '{8'h00, 8'h5A, 8'hFF};

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; file_rd_data = '0;
    m_w = 8'h00; m_c = 1'b0; m_dc = 1'b0; m_z = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (w_out !== 8'h00 || c_flag !== 1'b0 || dc_flag !== 1'b0 || z_flag !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: w=%h cdz=%b%b%b expected w=00 cdz=000", w_out, c_flag, dc_flag, z_flag);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (w_out !== 8'h00 || {c_flag, dc_flag, z_flag} !== 3'b000) begin
      errors++;
      $display("FAIL R1 after release: w=%h cdz=%b%b%b expected w=00 cdz=000", w_out, c_flag, dc_flag, z_flag);
    end

    // R3 add and R4 subtract, W swept in steps of 15, operand exhaustive
    for (int w = 0; w < 256; w += 15) begin
      for (int f = 0; f < 256; f++) begin
        load_w(w[7:0]);
        apply({6'b000111, f[0], 5'd3}, f[7:0], 1'b1);
        load_w(w[7:0]);
        apply({6'b000010, f[1], 5'd4}, f[7:0], 1'b1);
      end
    end

    // R5 rotates through carry, both carry-in values
    for (int c = 0; c < 2; c++) begin
      for (int f = 0; f < 256; f++) begin
        set_carry(c[0]);
        apply({6'b001101, f[2], 5'd7}, f[7:0], 1'b1);
        set_carry(c[0]);
        apply({6'b001100, f[3], 5'd7}, f[7:0], 1'b1);
      end
    end

    // R6 zero-only operations and R7 swap
    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s < 3; s++) begin
        for (int f = 0; f < 256; f++) begin
          load_w(WSET[s]);
          apply({ZOPS[o], f[4], 5'd9}, f[7:0], 1'b1);
        end
      end
    end

    // R8 clear file, clear W, move W to file
    for (int k = 0; k < 256; k++) begin
      load_w(k[7:0]);
      apply({7'b0000001, k[4:0]}, 8'hA5, 1'b1);
      apply({7'b0000011, k[4:0]}, k[7:0], 1'b1);
      apply(12'h040, k[7:0], 1'b1);
    end

    // R9 bit clear and set, every bit number and operand
    for (int b = 0; b < 8; b++) begin
      for (int f = 0; f < 256; f++) begin
        apply({4'b0100, b[2:0], 5'd1}, f[7:0], 1'b1);
        apply({4'b0101, b[2:0], 5'd2}, f[7:0], 1'b1);
      end
    end

    // R10 literal operations
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 256; k++) begin
        load_w(WSET[s]);
        apply({4'b1101, k[7:0]}, 8'h00, 1'b1);
        load_w(WSET[s]);
        apply({4'b1110, k[7:0]}, 8'h00, 1'b1);
        load_w(WSET[s]);
        apply({4'b1111, k[7:0]}, 8'h00, 1'b1);
      end
    end

    // R11 every instruction word, including unrecognised ones
    for (int i = 0; i < 4096; i++) begin
      apply(i[11:0], 8'((i * 37) % 256), 1'b1);
    end

    // R12 valid low: no effect for any kind of word
    load_w(8'h3C);
    for (int i = 0; i < 4096; i += 13) begin
      apply(i[11:0], 8'((i * 11) % 256), 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule